// File: doc/BRIEF.md
# Distributed-Arithmetic Row DCT

This block computes the one-dimensional 8-point forward DCT of one row of an 8×8 pixel block. No multipliers are used. Every product is built from small constant tables of coefficient partial sums, addressed by one bit-slice of the inputs at a time. The partial results are shifted and accumulated. A row of eight unsigned 8-bit pixels arrives in parallel with a one-cycle valid strobe. Eight signed coefficients leave one per cycle, each tagged with its frequency index.

The datapath has three stages. Stage one takes the row, subtracts 128 from every pixel, and holds the result. Stage two first forms the mirrored sums and differences of the held samples. It then runs one bit-slice per cycle through eight constant tables: four tables read the sums, which feed the even coefficients, and four read the differences, which feed the odd ones. Stage three rounds the eight accumulators and shifts the coefficients out in index order. The block is the row pass of a 2-D transform. The transpose store, the column pass and quantization sit outside it.

Top module: `dct8_da_row`

## Requirements
- R1: While reset is held and after it is released, out_valid stays low. A row presented during reset produces no output.
- R2: Each pixel p (unsigned, pixel n at in_row bits [8n+7:8n]) enters the transform as the signed sample x = p − 128. A row with every pixel at 128 gives eight zero coefficients.
- R3: Coefficient k equals floor((S + 4096) / 8192), where S = Σ x[n]·C(k,n). C(0,n) = 2896. For k > 0, C(k,n) = round(4096·cos((2n+1)kπ/16)).
- R4: Each accepted row yields exactly eight consecutive cycles of out_valid. out_idx counts 0,1,…,7 in order, and out_coef carries coefficient out_idx.
- R5: Coefficient 0 appears on the outputs right after the tenth rising edge that follows the edge sampling the row's in_valid.
- R6: Rows presented every 9 cycles are all accepted, and their output bursts follow one another 9 cycles apart.
- R7: Stage one holds at most one waiting row. A row presented while a row is waiting and stage two is not taking it is discarded. It yields no burst and does not disturb the waiting row.
- R8: Extreme rows (all 0, all 255, alternating 255/0) give exact results in the 12-bit signed output, with no wrap-around.
- R9: Ties round toward positive infinity. All pixels at 160 give coefficient 0 = 91, and all pixels at 96 give −90.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Row strobe, one cycle per row |
| in_row | input | 64 | Eight unsigned pixels, pixel n in bits [8n+7:8n] |
| out_valid | output | 1 | Coefficient valid |
| out_idx | output | 3 | Frequency index of out_coef |
| out_coef | output | 12 | Signed coefficient |

## Verification
The sign bit-slice is the easiest slice to get wrong. Rows whose samples are all negative, or mixed in sign, catch a design that adds that slice instead of subtracting it: such a design returns values off by a large power-of-two multiple. The two tie rows, with mirrored sums of +256 and −256, separate round-half-up from truncation or symmetric rounding; a wrong design would give 90 or −91. The back-to-back case presents three rows on consecutive cycles. A design that overwrites the waiting row would emit the third row's coefficients, and one that stalls wrongly would lose the second burst. Streaming rows at the 9-cycle rate shows whether the accumulators are cleared while the previous row's final sum is still being handed to the output stage.

// File: rtl/dct_da_pkg.sv
package dct_da_pkg;
  localparam int NPT    = 8;   // points per row
  localparam int HALF_N = 4;   // butterfly pairs
  localparam int CFRAC  = 13;  // fractional bits of the basis constants
  localparam int LUT_W  = 16;  // width of one table entry

  // 4096*cos(m*pi/16), m = 0..8
  function automatic int cos_q(input int m);
    case (m)
      0: return 4096;
      1: return 4017;
      2: return 3784;
      3: return 3406;
      4: return 2896;
      5: return 2276;
      6: return 1567;
      7: return 799;
      default: return 0;
    endcase
  endfunction

  // scaled basis value for frequency k and sample n
  function automatic int basis(input int k, input int n);
    int m;
    if (k == 0) return 2896;
    m = ((2 * n + 1) * k) % 32;
    if (m > 16) m = 32 - m;
    if (m > 8) return -cos_q(16 - m);
    return cos_q(m);
  endfunction

  // partial sum of basis values selected by one 4-bit slice
  function automatic int lut_entry(input int k, input logic [3:0] sel);
    int s;
    s = 0;
    for (int n = 0; n < HALF_N; n++)
      if (sel[n]) s = s + basis(k, n);
    return s;
  endfunction
endpackage

// File: rtl/dct_s1_capture.sv
module dct_s1_capture import dct_da_pkg::*; #(
  parameter int PIX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [NPT*PIX_W-1:0]   in_row,
  input  logic                   take,
  output logic                   full,
  output logic [NPT*PIX_W-1:0]   samples
);
  logic                 accept;
  logic [NPT*PIX_W-1:0] shifted;

  assign accept = in_valid && (!full || take);

  // subtract mid-scale: flipping the MSB maps 0..255 onto -128..127
  for (genvar n = 0; n < NPT; n++) begin : g_shift
    assign shifted[n*PIX_W +: PIX_W] =
      {~in_row[n*PIX_W + PIX_W - 1], in_row[n*PIX_W +: PIX_W-1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      samples <= '0;
    end else if (accept) begin
      full    <= 1'b1;
      samples <= shifted;
    end else if (take) begin
      full    <= 1'b0;
    end
  end

  // R7: a row arriving while one waits untaken leaves the held row alone
  p_hold_waiting_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !take) |=> (full && $stable(samples)));
endmodule

// File: rtl/dct_da_lane.sv
module dct_da_lane import dct_da_pkg::*; #(
  parameter int K     = 0,
  parameter int ACC_W = 27,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             sign_slice,
  input  logic [3:0]       sel,
  input  logic [CNT_W-1:0] cnt,
  output logic [ACC_W-1:0] acc_nxt
);
  logic signed [LUT_W-1:0] rom [16];
  logic signed [LUT_W-1:0] entry;
  logic signed [ACC_W-1:0] contrib;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] acc_sum;

  // constant table of the 16 partial sums for this frequency
  for (genvar e = 0; e < 16; e++) begin : g_rom
    assign rom[e] = LUT_W'(lut_entry(K, 4'(e)));
  end

  assign entry   = rom[sel];
  assign contrib = ACC_W'(entry) <<< cnt;
  assign acc_sum = sign_slice ? (acc - contrib) : (acc + contrib);
  assign acc_nxt = acc_sum;

  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (clr)  acc <= '0;
    else if (step) acc <= acc_sum;
  end
endmodule

// File: rtl/dct_da_engine.sv
module dct_da_engine import dct_da_pkg::*; #(
  parameter int PIX_W = 8,
  parameter int ACC_W = 27
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s1_full,
  input  logic [NPT*PIX_W-1:0] samples,
  output logic                 take,
  output logic                 done,
  output logic [NPT*ACC_W-1:0] acc_out
);
  localparam int BW    = PIX_W + 1;      // butterfly width = slice count
  localparam int CNT_W = $clog2(BW);

  logic                 busy;
  logic                 last;
  logic [CNT_W-1:0]     cnt;
  logic signed [BW-1:0] bf_e [HALF_N];
  logic signed [BW-1:0] bf_o [HALF_N];
  logic signed [BW-1:0] sh_e [HALF_N];
  logic signed [BW-1:0] sh_o [HALF_N];
  logic [3:0]           bits_e;
  logic [3:0]           bits_o;

  assign last = busy && (cnt == CNT_W'(BW - 1));
  assign take = s1_full && (!busy || last);
  assign done = last;

  for (genvar n = 0; n < HALF_N; n++) begin : g_bfly
    logic signed [PIX_W-1:0] xa, xb;
    assign xa        = samples[n*PIX_W +: PIX_W];
    assign xb        = samples[(NPT-1-n)*PIX_W +: PIX_W];
    assign bf_e[n]   = BW'(xa) + BW'(xb);
    assign bf_o[n]   = BW'(xa) - BW'(xb);
    assign bits_e[n] = sh_e[n][0];
    assign bits_o[n] = sh_o[n][0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      for (int n = 0; n < HALF_N; n++) begin
        sh_e[n] <= '0;
        sh_o[n] <= '0;
      end
    end else if (take) begin
      busy <= 1'b1;
      cnt  <= '0;
      for (int n = 0; n < HALF_N; n++) begin
        sh_e[n] <= bf_e[n];
        sh_o[n] <= bf_o[n];
      end
    end else if (busy) begin
      cnt <= last ? '0 : cnt + 1'b1;
      if (last) busy <= 1'b0;
      for (int n = 0; n < HALF_N; n++) begin
        sh_e[n] <= sh_e[n] >>> 1;
        sh_o[n] <= sh_o[n] >>> 1;
      end
    end
  end

  // even frequencies read the sums, odd ones the differences
  for (genvar k = 0; k < NPT; k++) begin : g_lane
    dct_da_lane #(.K(k), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (take),
      .step       (busy),
      .sign_slice (last),
      .sel        ((k % 2 == 0) ? bits_e : bits_o),
      .cnt        (cnt),
      .acc_nxt    (acc_out[k*ACC_W +: ACC_W])
    );
  end
endmodule

// File: rtl/dct_coef_out.sv
module dct_coef_out import dct_da_pkg::*; #(
  parameter int ACC_W = 27,
  parameter int OUT_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [NPT*ACC_W-1:0]  acc_in,
  output logic                  out_valid,
  output logic [$clog2(NPT)-1:0] out_idx,
  output logic [OUT_W-1:0]      out_coef
);
  localparam int IDX_W = $clog2(NPT);
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (CFRAC - 1);
  localparam logic signed [ACC_W-1:0] MAX_V = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MIN_V = -ACC_W'(1 << (OUT_W - 1));

  logic [OUT_W-1:0] coef_q [NPT];
  logic [OUT_W-1:0] coef_d [NPT];
  logic             busy;
  logic [IDX_W-1:0] idx;

  for (genvar k = 0; k < NPT; k++) begin : g_rnd
    logic signed [ACC_W-1:0] acc_k, rnd_k;
    assign acc_k     = acc_in[k*ACC_W +: ACC_W];
    assign rnd_k     = (acc_k + HALF_LSB) >>> CFRAC;
    assign coef_d[k] = rnd_k[OUT_W-1:0];

    // R8: the rounded coefficient fits the output word
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (rnd_k <= MAX_V && rnd_k >= MIN_V));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      for (int k = 0; k < NPT; k++) coef_q[k] <= '0;
    end else if (load) begin
      busy <= 1'b1;
      idx  <= '0;
      for (int k = 0; k < NPT; k++) coef_q[k] <= coef_d[k];
    end else if (busy) begin
      idx <= idx + 1'b1;
      if (idx == IDX_W'(NPT - 1)) busy <= 1'b0;
    end
  end

  assign out_valid = busy;
  assign out_idx   = idx;
  assign out_coef  = coef_q[idx];

  // R4: bursts start at index 0 and step by one without gaps
  p_first_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_idx == '0));
  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx != IDX_W'(NPT - 1)) |=>
      (out_valid && out_idx == $past(out_idx) + 1'b1));
endmodule

// File: rtl/dct8_da_row.sv
module dct8_da_row import dct_da_pkg::*; #(
  parameter int PIX_W = 8,
  parameter int OUT_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [NPT*PIX_W-1:0] in_row,
  output logic                 out_valid,
  output logic [2:0]           out_idx,
  output logic [OUT_W-1:0]     out_coef
);
  localparam int BW    = PIX_W + 1;
  localparam int ACC_W = BW + LUT_W + 2;

  logic                 s1_full;
  logic [NPT*PIX_W-1:0] samples;
  logic                 take;
  logic                 eng_done;
  logic [NPT*ACC_W-1:0] acc_bus;

  dct_s1_capture #(.PIX_W(PIX_W)) u_s1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_row   (in_row),
    .take     (take),
    .full     (s1_full),
    .samples  (samples)
  );

  dct_da_engine #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_s2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .s1_full (s1_full),
    .samples (samples),
    .take    (take),
    .done    (eng_done),
    .acc_out (acc_bus)
  );

  dct_coef_out #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_s3 (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (eng_done),
    .acc_in    (acc_bus),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_coef  (out_coef)
  );

  // R5: a finished accumulation is on the outputs one edge later
  p_done_to_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (out_valid && out_idx == 3'd0));
endmodule

// File: tb/sim_dct8_da_row.sv
module sim_dct8_da_row;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_row = '0;
  logic        out_valid;
  logic [2:0]  out_idx;
  logic [11:0] out_coef;

  integer vec = 0, bad = 0, cyc = 0, n_got = 0;
  integer got_coef [0:63];
  integer got_idx  [0:63];
  integer got_cyc  [0:63];
  logic   finished = 1'b0;

  dct8_da_row u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_row(in_row),
    .out_valid(out_valid), .out_idx(out_idx), .out_coef(out_coef)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid && n_got < 64) begin
      got_coef[n_got] = $signed(out_coef);
      got_idx[n_got]  = out_idx;
      got_cyc[n_got]  = cyc;
      n_got = n_got + 1;
    end
  end

  function automatic integer rnd_int(input real r);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  function automatic integer basis_tb(input integer k, input integer n);
    if (k == 0) return rnd_int(4096.0 / $sqrt(2.0));
    return rnd_int(4096.0 * $cos((2 * n + 1) * k * 3.14159265358979 / 16.0));
  endfunction

  // R3: direct 8-term dot product with round-half-up
  function automatic integer model(input logic [63:0] row, input integer k);
    integer s;
    s = 0;
    for (int n = 0; n < 8; n++)
      s = s + (integer'(row[n*8 +: 8]) - 128) * basis_tb(k, n);
    return (s + 4096) >>> 13;
  endfunction

  function automatic logic [63:0] flat(input logic [7:0] p);
    return {8{p}};
  endfunction

  task automatic chk(input string req, input string what, input integer act, input integer exp);
    vec = vec + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_burst(input string req, input logic [63:0] row,
                             input integer slot, input integer start);
    for (int i = 0; i < 8; i++) begin
      chk(req, "coefficient", got_coef[slot*8 + i], model(row, i));
      chk("R4", "index order", got_idx[slot*8 + i], i);
      chk("R5", "output cycle", got_cyc[slot*8 + i], start + i);
    end
  endtask

  task automatic run_single(input string req, input logic [63:0] row);
    integer t0;
    @(negedge clk);
    n_got = 0;
    in_valid = 1'b1; in_row = row; t0 = cyc;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk("R4", "burst length", n_got, 8);
    check_burst(req, row, 0, t0 + 11);
  endtask

  task automatic test_reset_r1();
    rst_n = 1'b0; in_valid = 1'b1; in_row = 64'h0123456789abcdef;
    repeat (4) begin
      @(negedge clk);
      chk("R1", "out_valid in reset", out_valid, 0);
    end
    rst_n = 1'b1; in_valid = 1'b0;
    n_got = 0;
    repeat (20) @(negedge clk);
    chk("R1", "no output after reset", n_got, 0);
  endtask

  task automatic test_r2_mid();
    run_single("R2", flat(8'd128));
    for (int i = 0; i < 8; i++) chk("R2", "mid-scale zero", got_coef[i], 0);
  endtask

  task automatic test_r8_extremes();
    run_single("R8", flat(8'd255));
    chk("R8", "DC all-255", got_coef[0], 359);
    run_single("R8", flat(8'd0));
    chk("R8", "DC all-0", got_coef[0], -362);
    run_single("R8", 64'h00ff00ff00ff00ff);
    run_single("R8", 64'hff00ff00ff00ff00);
  endtask

  task automatic test_r3_patterns();
    logic [31:0] lf;
    logic [63:0] row;
    run_single("R3", 64'he0c0a08060402000);
    run_single("R3", 64'h00204060_80a0c0e0);
    run_single("R3", 64'h7f7f7f7f80808080);
    lf = 32'h1badc0de;
    for (int r = 0; r < 5; r++) begin
      for (int b = 0; b < 2; b++) begin
        lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
        row[b*32 +: 32] = lf;
      end
      run_single("R3", row);
    end
  endtask

  task automatic test_r9_ties();
    run_single("R9", flat(8'd160));
    chk("R9", "positive tie", got_coef[0], 91);
    run_single("R9", flat(8'd96));
    chk("R9", "negative tie", got_coef[0], -90);
  endtask

  task automatic test_r7_drop();
    logic [63:0] ra, rb, rc;
    integer t0;
    ra = 64'h1020304050607080; rb = 64'hf0e0d0c0b0a09080; rc = flat(8'd0);
    @(negedge clk);
    n_got = 0;
    in_valid = 1'b1; in_row = ra; t0 = cyc;
    @(negedge clk); in_row = rb;
    @(negedge clk); in_row = rc;
    @(negedge clk); in_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk("R7", "bursts for three rows", n_got, 16);
    check_burst("R7", ra, 0, t0 + 11);
    check_burst("R7", rb, 1, t0 + 20);
  endtask

  task automatic test_r6_stream();
    logic [63:0] rows [4];
    integer t0;
    rows[0] = flat(8'd10);  rows[1] = 64'h80ff80ff00800080;
    rows[2] = 64'h55aa55aa33cc33cc; rows[3] = flat(8'd250);
    @(negedge clk);
    n_got = 0; t0 = cyc;
    for (int j = 0; j < 4; j++) begin
      in_valid = 1'b1; in_row = rows[j];
      @(negedge clk);
      in_valid = 1'b0;
      repeat (8) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    chk("R6", "bursts streamed", n_got, 32);
    for (int j = 0; j < 4; j++) check_burst("R6", rows[j], j, t0 + 11 + 9*j);
  endtask

  initial begin
    test_reset_r1();
    test_r2_mid();
    test_r8_extremes();
    test_r3_patterns();
    test_r9_ties();
    test_r7_drop();
    test_r6_stream();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      vec = vec + 1; bad = bad + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule